// File: doc/BRIEF.md
# Receive Buffer Watermark Flow Controller

This block counts the received packets that sit in receive buffers owned by software, waiting to be processed. The receive path raises a one-cycle pulse each time it stores a packet. Software raises a one-cycle pulse each time it hands a buffer back. The count is compared against a full threshold and an empty threshold. Three status flags follow from these comparisons: full, empty and pending. Each flag can be routed to a single interrupt line through an enable mask.

When automatic mode is on, the block turns a flow-control request on when the count reaches the full threshold. It turns the request off again once the count has fallen to the empty threshold. The gap between the two thresholds gives hysteresis. Each change of state produces a one-cycle request toward the transmit side. An assert request carries the configured pause time. A release request carries zero quanta. Building the pause frame and the DMA engine lie outside this block.

Top module: `rxwm_flow_ctrl`

## Requirements
- R1: With `mod_on` high, a `pkt_stored` pulse raises `buf_count` by one and a `sw_dec` pulse lowers it by one, each on the next clock edge. Both pulses in the same cycle leave the count unchanged.
- R2: `buf_count` saturates. A store at 255 leaves 255, and a decrement at 0 leaves 0.
- R3: The full flag (`stat_flags[0]`) sets on the edge at which the new count is greater than or equal to `full_mark`. Once set, it clears only on an edge at which a decrement actually lowers the count, and only if the new count is then below `full_mark`.
- R4: The empty flag (`stat_flags[1]`) sets on the edge at which the new count is less than or equal to `empty_mark`. Once set, it clears only on an edge at which a store actually raises the count, and only if the new count is then above `empty_mark`.
- R5: The pending flag (`stat_flags[2]`) is high exactly when `buf_count` is non-zero.
- R6: `irq` is high whenever some flag is set and its bit in `irq_en` is set (bit 0 full, bit 1 empty, bit 2 pending). The flags read the same whatever the value of `irq_en`.
- R7: With `auto_fc_en` high, `fc_active` turns on at the edge where the new count is at or above `full_mark`. It stays on until the new count is at or below `empty_mark`. Dropping `auto_fc_en` releases it on the next edge.
- R8: Each rise of `fc_active` comes with a one-cycle `pause_req_valid` and `pause_req_quanta` equal to the held pause time. Each release while `mod_on` is high comes with a one-cycle `pause_req_valid` and quanta of 0. At all other times `pause_req_valid` is low and `pause_req_quanta` is 0.
- R9: The held pause time loads `pause_time_in` on every edge while `rx_enable` is low. It ignores `pause_time_in` while `rx_enable` is high.
- R10: While `mod_on` is low, the count, the flags, `fc_active` and the pause request are all cleared on the next edge, and both pulse inputs are ignored. No release request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_on | input | 1 | Module enable; low clears the counting and flow-control state |
| rx_enable | input | 1 | Receive enable; while low the pause time may be loaded |
| auto_fc_en | input | 1 | Enables automatic flow control |
| pkt_stored | input | 1 | One-cycle pulse: a packet was stored in a buffer |
| sw_dec | input | 1 | One-cycle pulse: software returned a buffer |
| full_mark | input | 8 | Full threshold |
| empty_mark | input | 8 | Empty threshold, expected below `full_mark` |
| pause_time_in | input | 16 | Pause time in quanta |
| irq_en | input | 3 | Interrupt enables for {pending, empty, full} |
| buf_count | output | 8 | Packets waiting |
| stat_flags | output | 3 | {pending, empty, full} status flags |
| irq | output | 1 | Combined interrupt |
| fc_active | output | 1 | Flow-control request state |
| pause_req_valid | output | 1 | One-cycle pause request strobe |
| pause_req_quanta | output | 16 | Quanta for the current request, 0 when idle |

## Verification
A count that drifts by a single step shows on `buf_count` at the very next edge. It then spreads within a cycle into the flags, `irq` and `fc_active`. A flag that clears on the wrong kind of event stays visible only until the count next crosses its threshold. For that reason the stimulus holds the count near each threshold while it mixes stores and decrements. A hysteresis state that is wrong appears as a spurious or missing pause request, in the same cycle as the count change that should have caused it.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
   localparam int FLG_FULL  = 0;
   localparam int FLG_EMPTY = 1;
   localparam int FLG_PEND  = 2;
   localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/rxwm_counter.sv
module rxwm_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on,
   input  logic             inc_req,
   input  logic             dec_req,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             inc_done,
   output logic             dec_done
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_comb begin
      inc_done = on & inc_req & ~dec_req & (cnt_q != CNT_MAX);
      dec_done = on & dec_req & ~inc_req & (cnt_q != '0);
      if (!on)           cnt_nxt = '0;
      else if (inc_done) cnt_nxt = cnt_q + CNT_ONE;
      else if (dec_done) cnt_nxt = cnt_q - CNT_ONE;
      else               cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   p_simul_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (on && inc_req && dec_req) |=> $stable(cnt_q));
   p_top_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (on && cnt_q == CNT_MAX && !dec_req) |=> cnt_q == CNT_MAX);
   p_bot_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (on && cnt_q == '0 && !inc_req) |=> cnt_q == '0);
   p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !on |=> cnt_q == '0);
endmodule

// File: rtl/rxwm_flags.sv
module rxwm_flags
   import rxwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 on,
   input  logic [CNT_W-1:0]     cnt_q,
   input  logic [CNT_W-1:0]     cnt_nxt,
   input  logic                 inc_done,
   input  logic                 dec_done,
   input  logic [CNT_W-1:0]     full_mark,
   input  logic [CNT_W-1:0]     empty_mark,
   output logic [NUM_FLAGS-1:0] flags_q
);
   logic [NUM_FLAGS-1:0] set_cond;
   logic [NUM_FLAGS-1:0] clr_evt;
   logic [NUM_FLAGS-1:0] flags_nxt;

   always_comb begin
      set_cond            = '0;
      clr_evt             = '0;
      set_cond[FLG_FULL]  = (cnt_nxt >= full_mark);
      clr_evt[FLG_FULL]   = dec_done;
      set_cond[FLG_EMPTY] = (cnt_nxt <= empty_mark);
      clr_evt[FLG_EMPTY]  = inc_done;
      set_cond[FLG_PEND]  = (cnt_nxt != '0);
      clr_evt[FLG_PEND]   = 1'b1;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      assign flags_nxt[g] = on & ((flags_q[g] & ~clr_evt[g]) | set_cond[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_nxt;
   end

   p_full_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (on && flags_q[FLG_FULL] && !dec_done) |=> flags_q[FLG_FULL]);
   p_empty_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (on && flags_q[FLG_EMPTY] && !inc_done) |=> flags_q[FLG_EMPTY]);
   p_pend_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[FLG_PEND] == (cnt_q != '0));
   p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !on |=> flags_q == '0);
endmodule

// File: rtl/rxwm_pause.sv
module rxwm_pause #(
   parameter int CNT_W   = 8,
   parameter int PAUSE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               on,
   input  logic               rx_en,
   input  logic               auto_en,
   input  logic [PAUSE_W-1:0] pause_in,
   input  logic [CNT_W-1:0]   cnt_nxt,
   input  logic [CNT_W-1:0]   full_mark,
   input  logic [CNT_W-1:0]   empty_mark,
   output logic               fc_q,
   output logic               req_valid,
   output logic [PAUSE_W-1:0] req_quanta
);
   logic [PAUSE_W-1:0] pv_q;
   logic               on_evt;
   logic               off_evt;

   always_comb begin
      on_evt  = on & auto_en & ~fc_q & (cnt_nxt >= full_mark);
      off_evt = on & fc_q & (~auto_en | (cnt_nxt <= empty_mark));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pv_q <= '0;
      else if (!rx_en) pv_q <= pause_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fc_q       <= 1'b0;
         req_valid  <= 1'b0;
         req_quanta <= '0;
      end else begin
         if (!on)          fc_q <= 1'b0;
         else if (on_evt)  fc_q <= 1'b1;
         else if (off_evt) fc_q <= 1'b0;
         req_valid  <= on_evt | off_evt;
         req_quanta <= on_evt ? pv_q : '0;
      end
   end

   p_fc_hyst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (on && auto_en && fc_q && cnt_nxt > empty_mark) |=> fc_q);
   p_req_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fc_q) |-> req_valid);
   p_req_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fc_q) && $past(on)) |-> (req_valid && req_quanta == '0));
   p_pv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en |=> $stable(pv_q));
endmodule

// File: rtl/rxwm_flow_ctrl.sv
module rxwm_flow_ctrl
   import rxwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int PAUSE_W = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mod_on,
   input  logic                 rx_enable,
   input  logic                 auto_fc_en,
   input  logic                 pkt_stored,
   input  logic                 sw_dec,
   input  logic [CNT_W-1:0]     full_mark,
   input  logic [CNT_W-1:0]     empty_mark,
   input  logic [PAUSE_W-1:0]   pause_time_in,
   input  logic [NUM_FLAGS-1:0] irq_en,
   output logic [CNT_W-1:0]     buf_count,
   output logic [NUM_FLAGS-1:0] stat_flags,
   output logic                 irq,
   output logic                 fc_active,
   output logic                 pause_req_valid,
   output logic [PAUSE_W-1:0]   pause_req_quanta
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("rxwm_flow_ctrl: CNT_W out of range");
   end
   if (PAUSE_W < 1 || PAUSE_W > 32) begin : g_bad_pause
      $error("rxwm_flow_ctrl: PAUSE_W out of range");
   end

   logic [CNT_W-1:0] cnt_nxt;
   logic             inc_done;
   logic             dec_done;

   rxwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .on       (mod_on),
      .inc_req  (pkt_stored),
      .dec_req  (sw_dec),
      .cnt_q    (buf_count),
      .cnt_nxt  (cnt_nxt),
      .inc_done (inc_done),
      .dec_done (dec_done)
   );

   rxwm_flags #(.CNT_W(CNT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .on         (mod_on),
      .cnt_q      (buf_count),
      .cnt_nxt    (cnt_nxt),
      .inc_done   (inc_done),
      .dec_done   (dec_done),
      .full_mark  (full_mark),
      .empty_mark (empty_mark),
      .flags_q    (stat_flags)
   );

   rxwm_pause #(.CNT_W(CNT_W), .PAUSE_W(PAUSE_W)) u_pause (
      .clk        (clk),
      .rst_n      (rst_n),
      .on         (mod_on),
      .rx_en      (rx_enable),
      .auto_en    (auto_fc_en),
      .pause_in   (pause_time_in),
      .cnt_nxt    (cnt_nxt),
      .full_mark  (full_mark),
      .empty_mark (empty_mark),
      .fc_q       (fc_active),
      .req_valid  (pause_req_valid),
      .req_quanta (pause_req_quanta)
   );

   logic irq_raw;
   assign irq_raw = |(stat_flags & irq_en);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   p_idle_req_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_req_valid |-> pause_req_quanta == '0);
   p_off_fc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_on |=> (!fc_active && !pause_req_valid));
endmodule

// File: tb/tb_rxwm_flow_ctrl.sv
module tb_rxwm_flow_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_on = 1'b0, rx_enable = 1'b0, auto_fc_en = 1'b0;
   logic        pkt_stored = 1'b0, sw_dec = 1'b0;
   logic [7:0]  full_mark = 8'd6, empty_mark = 8'd2;
   logic [15:0] pause_time_in = 16'h0;
   logic [2:0]  irq_en = 3'b000;
   logic [7:0]  buf_count;
   logic [2:0]  stat_flags;
   logic        irq, fc_active, pause_req_valid;
   logic [15:0] pause_req_quanta;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference state
   int m_cnt = 0, m_pv = 0, m_q = 0;
   bit m_ff = 0, m_ef = 0, m_pf = 0, m_fc = 0, m_req = 0;

   always #4 clk = ~clk;

   rxwm_flow_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .rx_enable(rx_enable),
      .auto_fc_en(auto_fc_en), .pkt_stored(pkt_stored), .sw_dec(sw_dec),
      .full_mark(full_mark), .empty_mark(empty_mark),
      .pause_time_in(pause_time_in), .irq_en(irq_en),
      .buf_count(buf_count), .stat_flags(stat_flags), .irq(irq),
      .fc_active(fc_active), .pause_req_valid(pause_req_valid),
      .pause_req_quanta(pause_req_quanta)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit inc, dec, on_e, off_e;
      int nc;
      if (!mod_on) begin
         m_cnt = 0; m_ff = 0; m_ef = 0; m_pf = 0; m_fc = 0; m_req = 0; m_q = 0;
      end else begin
         inc = pkt_stored && !sw_dec && m_cnt < 255;
         dec = sw_dec && !pkt_stored && m_cnt > 0;
         nc  = m_cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
         m_ff = (m_ff && !dec) || (nc >= int'(full_mark));
         m_ef = (m_ef && !inc) || (nc <= int'(empty_mark));
         m_pf = (nc != 0);
         on_e  = auto_fc_en && !m_fc && nc >= int'(full_mark);
         off_e = m_fc && (!auto_fc_en || nc <= int'(empty_mark));
         if (on_e) m_fc = 1; else if (off_e) m_fc = 0;
         m_req = on_e || off_e;
         m_q   = on_e ? m_pv : 0;
         m_cnt = nc;
      end
      if (!rx_enable) m_pv = int'(pause_time_in);
   endtask

   task automatic compare_all();
      bit mirq;
      mirq = (m_ff && irq_en[0]) || (m_ef && irq_en[1]) || (m_pf && irq_en[2]);
      chk(int'(buf_count) == m_cnt, "R1/R2 buf_count", int'(buf_count), m_cnt);
      chk(stat_flags[0] == m_ff, "R3 full flag", int'(stat_flags[0]), int'(m_ff));
      chk(stat_flags[1] == m_ef, "R4 empty flag", int'(stat_flags[1]), int'(m_ef));
      chk(stat_flags[2] == m_pf, "R5 pending flag", int'(stat_flags[2]), int'(m_pf));
      chk(irq == mirq, "R6 irq", int'(irq), int'(mirq));
      chk(fc_active == m_fc, "R7 fc_active", int'(fc_active), int'(m_fc));
      chk(pause_req_valid == m_req, "R8 pause_req_valid", int'(pause_req_valid), int'(m_req));
      chk(int'(pause_req_quanta) == m_q, "R8/R9 pause_req_quanta", int'(pause_req_quanta), m_q);
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step();
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic run_phase(input int n, input int p_st, input int p_dec, input bit misc);
      for (int i = 0; i < n; i++) begin
         pkt_stored = (($urandom % 100) < p_st);
         sw_dec     = (($urandom % 100) < p_dec);
         if (misc) begin
            if (($urandom % 8) == 0) rx_enable = ~rx_enable;
            pause_time_in = 16'($urandom);
            if (($urandom % 10) == 0) auto_fc_en = ~auto_fc_en;
            irq_en = 3'($urandom);
            mod_on = (($urandom % 60) != 0);
         end
         step();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all();  // reset state: R10 all cleared

      // R9: load pause time while receive disabled, then lock it
      pause_time_in = 16'h1234;
      step();
      rx_enable = 1'b1;
      pause_time_in = 16'hBEEF;
      mod_on = 1'b1; auto_fc_en = 1'b1; irq_en = 3'b111;
      run_phase(400, 60, 40, 0);
      run_phase(400, 30, 60, 0);

      // R2: saturation at both ends
      full_mark = 8'd250; empty_mark = 8'd5;
      run_phase(600, 95, 0, 0);
      chk(buf_count == 8'd255, "R2 top saturation", int'(buf_count), 255);
      run_phase(600, 0, 95, 0);
      chk(buf_count == 8'd0, "R2 bottom saturation", int'(buf_count), 0);

      // R1: simultaneous pulses
      pkt_stored = 1; sw_dec = 0; step(); step();
      pkt_stored = 1; sw_dec = 1; step();
      chk(buf_count == 8'd2, "R1 simultaneous hold", int'(buf_count), 2);

      // R6: flags readable with interrupts masked
      irq_en = 3'b000; pkt_stored = 0; sw_dec = 0; step();
      chk(irq == 1'b0 && stat_flags[2], "R6 masked irq", int'(irq), 0);

      // R10: drop module-on mid-stream with flow control active
      full_mark = 8'd4; empty_mark = 8'd1; irq_en = 3'b111;
      pkt_stored = 1; repeat (4) step();
      chk(fc_active == 1'b1, "R7 fc on at full", int'(fc_active), 1);
      mod_on = 0; pkt_stored = 1; step();
      chk(buf_count == 0 && stat_flags == 0 && !fc_active && !pause_req_valid,
          "R10 module off clears", int'(buf_count), 0);
      mod_on = 1; pkt_stored = 0;

      // mixed random traffic near thresholds
      run_phase(1500, 50, 50, 1);
      full_mark = 8'd9; empty_mark = 8'd3; mod_on = 1;
      run_phase(1500, 55, 45, 1);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule